// File: doc/BRIEF.md
# Dual-Sequence Conversion Scheduler

This block decides which analog channel a shared converter samples next. Two independent sequences, A and B, each hold a set of selected channels. Each sequence has its own launch sources: a software start pulse, or an edge on any hardware trigger line it has selected. Each also has its own repeat, one-channel-per-launch and completion-event settings. The converter is outside the block. The block asks it for one conversion at a time with a request/done handshake, and it reports every finished conversion together with the sequence and channel it belongs to.

When both sequences have work, a single priority input picks the winner. The preemption happens at the boundary between conversions. The conversion already underway finishes. The preempting sequence then takes the converter for its whole pass. After that, the other sequence carries on with the first of its channels that it has not yet converted.

Top module: `convseq_sched`

## Requirements
- R1: Within a pass, the selected channels (bit i of a sequence's channel mask selects channel i; sequence A uses the low NCH bits, B the high NCH bits) are converted one by one, from the lowest-numbered selected channel upward.
- R2: While a sequence's enable bit is 0, its software start pulse and its hardware triggers launch nothing, and no conversion request appears.
- R3: A sequence launches on an edge of the programmed polarity (1 = rising, 0 = falling) on a trigger line selected in its 6-bit trigger mask, or on its software start pulse. Edges on unselected lines, and edges of the opposite polarity, launch nothing.
- R4: With the synchronizer bypass set, conv_req rises at the second clock edge counting from the edge that first samples the new trigger level. With the bypass clear, the path has a two-flop synchronizer and conv_req rises two edges later, at the fourth edge.
- R5: With single-step set, each launch converts only the next unconverted channel of the pass. A launch after the last channel starts a new pass from the lowest channel.
- R6: With burst set, an enabled sequence restarts its pass by itself at each end of pass and ignores its launch sources. Once burst is cleared, the pass in progress completes and conversions then stop.
- R7: With event mode 0, the sequence's event bit in seq_irq pulses with every result of that sequence. With event mode 1, it pulses only with the result that ends a pass.
- R8: When both sequences have work, the next request goes to the high-priority sequence (prio_a = 1: A, 0: B). The conversion already underway finishes first. The other sequence later resumes with its first unconverted channel.
- R9: A launch that arrives while the same sequence still has conversions pending is ignored and does not add another pass.
- R10: One cycle after a clock edge that sees conv_req and conv_done both high, res_valid pulses for one cycle. In that cycle res_seq (0 = A, 1 = B) and res_ch give the converted sequence and channel, and res_last marks the end of a pass.
- R11: conv_req stays high, with conv_seq and conv_ch held steady, until conv_done is seen. It then drops for at least one cycle.
- R12: After reset, conv_req, res_valid and seq_irq are low and no sequence has pending work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_en | input | 2 | Per-sequence enable (bit 0 = A, bit 1 = B) |
| prio_a | input | 1 | 1: A has priority, 0: B has priority |
| seq_chmask | input | 2*NCH | Channel selection, A in the low half |
| seq_trigmask | input | 2*NTRIG | Hardware trigger line selection, A in the low half |
| seq_trigpol | input | 2 | Trigger edge polarity per sequence, 1 = rising |
| seq_sync_bypass | input | 2 | 1: skip the trigger synchronizer |
| seq_swstart | input | 2 | Software start pulse per sequence |
| seq_burst | input | 2 | Continuous repeat per sequence |
| seq_step | input | 2 | One channel per launch |
| seq_evmode | input | 2 | 0: event per conversion, 1: event per pass |
| hw_trig | input | NTRIG | Hardware trigger lines |
| conv_req | output | 1 | Conversion request to the converter |
| conv_seq | output | 1 | Sequence owning the request |
| conv_ch | output | CHW | Channel to convert |
| conv_done | input | 1 | Converter completion strobe |
| res_valid | output | 1 | Result pulse |
| res_seq | output | 1 | Sequence of the result |
| res_ch | output | CHW | Channel of the result |
| res_last | output | 1 | Result ends a pass |
| seq_irq | output | 2 | Per-sequence completion event |

## Verification
The collision that matters is a launch of the high-priority sequence landing while the low-priority sequence's conversion is in flight. The priority decision and the low sequence's remaining-channel update then fall into the same window. The bench provokes this twice, once with each sequence as the winner. It starts the low sequence, waits until its first request is visible, and then starts the other one. A scoreboard then requires the exact interleaving: the first low channel, the whole high pass, and then the rest of the low pass. A second coincidence, a hardware edge and a software start in the same cycle, must produce a single pass.

// File: rtl/convseq_pkg.sv
// Package: shared constants for the dual-sequence conversion scheduler.
// Assumes exactly two sequences; index 0 is sequence A, index 1 is B.
package convseq_pkg;
    localparam int NSEQ = 2;
    localparam logic SEQ_A = 1'b0;
    localparam logic SEQ_B = 1'b1;
endpackage

// File: rtl/convseq_trig.sv
// Module: convseq_trig
// Turns a set of raw hardware trigger lines into a one-cycle launch pulse.
// The selected lines are watched for edges of the programmed polarity,
// either directly (bypass) or after a two-flop synchronizer.
// Assumes the raw lines may be asynchronous to clk.
module convseq_trig #(
    parameter int NTRIG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] raw,
    input  logic [NTRIG-1:0] sel,
    input  logic             rising,
    input  logic             bypass,
    output logic             launch
);
    logic [NTRIG-1:0] sync1, sync2, sync3, raw_d;
    logic [NTRIG-1:0] cur, old, edges;

    // Synchronizer chain and a delayed copy of the raw lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            sync3 <= '0;
            raw_d <= '0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
            sync3 <= sync2;
            raw_d <= raw;
        end
    end

    // Pick the direct or synchronized path and find edges of the chosen polarity.
    always_comb begin
        cur    = bypass ? raw   : sync2;
        old    = bypass ? raw_d : sync3;
        edges  = rising ? (cur & ~old) : (~cur & old);
        launch = |(edges & sel);
    end
endmodule

// File: rtl/convseq_lane.sv
// Module: convseq_lane
// State of one sequence: the channels still to convert in the current pass
// and whether it currently asks for the converter. Handles launch gating,
// single-step, burst looping and end-of-pass detection.
// Assumes done_hit only arrives while pending is high.
module convseq_lane #(
    parameter int NCH = 12,
    parameter int CHW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [NCH-1:0] chmask,
    input  logic           burst,
    input  logic           step,
    input  logic           launch,
    input  logic           done_hit,
    input  logic [CHW-1:0] done_ch,
    output logic           pending,
    output logic [CHW-1:0] next_ch,
    output logic           pass_end
);
    logic [NCH-1:0] remain, remain_after, reload;
    logic           go;

    // Index of the lowest set bit, used to walk the pass upward.
    function automatic logic [CHW-1:0] first_set(input logic [NCH-1:0] v);
        first_set = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) first_set = CHW'(i);
        end
    endfunction

    // Launch gating, remaining set after a completion, and end-of-pass flag.
    always_comb begin
        go           = en && !pending && (burst || launch);
        reload       = (remain == '0) ? chmask : remain;
        remain_after = remain & ~(NCH'(1) << done_ch);
        pass_end     = done_hit && (remain_after == '0);
        next_ch      = first_set(remain);
    end

    // Pass bookkeeping: load on launch, retire channels on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            pending <= 1'b0;
        end else if (done_hit) begin
            if (remain_after != '0) begin
                remain  <= remain_after;
                pending <= !(step && !burst);
            end else if (burst && en) begin
                remain  <= chmask;
                pending <= (chmask != '0);
            end else begin
                remain  <= '0;
                pending <= 1'b0;
            end
        end else if (go) begin
            remain  <= reload;
            pending <= (reload != '0);
        end
    end
endmodule

// File: rtl/convseq_issue.sv
// Module: convseq_issue
// Grants the single converter to one of the two sequences and holds the
// request until the converter answers. Priority is resolved only when the
// converter is free, so a running conversion is never cut short.
// Assumes two sequences (package NSEQ = 2).
module convseq_issue
    import convseq_pkg::*;
#(
    parameter int CHW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSEQ-1:0]     pending,
    input  logic [NSEQ*CHW-1:0] next_ch,
    input  logic                prio_a,
    input  logic                conv_done,
    output logic                conv_req,
    output logic                conv_seq,
    output logic [CHW-1:0]      conv_ch
);
    logic pick;

    // Winner when the converter is free.
    always_comb begin
        if (pending == 2'b11) pick = prio_a ? SEQ_A : SEQ_B;
        else                  pick = pending[1] ? SEQ_B : SEQ_A;
    end

    // Request register: issue when idle, release on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_req <= 1'b0;
            conv_seq <= SEQ_A;
            conv_ch  <= '0;
        end else if (conv_req) begin
            if (conv_done) conv_req <= 1'b0;
        end else if (|pending) begin
            conv_req <= 1'b1;
            conv_seq <= pick;
            conv_ch  <= next_ch[int'(pick)*CHW +: CHW];
        end
    end
endmodule

// File: rtl/convseq_sched.sv
// Module: convseq_sched (top)
// Dual-sequence conversion scheduler: per-sequence trigger detection and
// pass state, a shared converter grant, and registered result reporting.
// Assumes a converter that answers each request with one conv_done pulse.
module convseq_sched
    import convseq_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int NTRIG = 6,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           seq_en,
    input  logic                 prio_a,
    input  logic [2*NCH-1:0]     seq_chmask,
    input  logic [2*NTRIG-1:0]   seq_trigmask,
    input  logic [1:0]           seq_trigpol,
    input  logic [1:0]           seq_sync_bypass,
    input  logic [1:0]           seq_swstart,
    input  logic [1:0]           seq_burst,
    input  logic [1:0]           seq_step,
    input  logic [1:0]           seq_evmode,
    input  logic [NTRIG-1:0]     hw_trig,
    output logic                 conv_req,
    output logic                 conv_seq,
    output logic [CHW-1:0]       conv_ch,
    input  logic                 conv_done,
    output logic                 res_valid,
    output logic                 res_seq,
    output logic [CHW-1:0]       res_ch,
    output logic                 res_last,
    output logic [1:0]           seq_irq
);
    logic [NSEQ-1:0]     hw_launch, lane_want, done_hit, pass_end;
    logic [NSEQ*CHW-1:0] lane_next;
    logic                accept;

    assign accept = conv_req && conv_done;

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        assign done_hit[s] = accept && (conv_seq == s[0]);

        convseq_trig #(.NTRIG(NTRIG)) u_trig (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (hw_trig),
            .sel    (seq_trigmask[s*NTRIG +: NTRIG]),
            .rising (seq_trigpol[s]),
            .bypass (seq_sync_bypass[s]),
            .launch (hw_launch[s])
        );

        convseq_lane #(.NCH(NCH), .CHW(CHW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (seq_en[s]),
            .chmask   (seq_chmask[s*NCH +: NCH]),
            .burst    (seq_burst[s]),
            .step     (seq_step[s]),
            .launch   (hw_launch[s] || seq_swstart[s]),
            .done_hit (done_hit[s]),
            .done_ch  (conv_ch),
            .pending  (lane_want[s]),
            .next_ch  (lane_next[s*CHW +: CHW]),
            .pass_end (pass_end[s])
        );
    end

    convseq_issue #(.CHW(CHW)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (lane_want),
        .next_ch   (lane_next),
        .prio_a    (prio_a),
        .conv_done (conv_done),
        .conv_req  (conv_req),
        .conv_seq  (conv_seq),
        .conv_ch   (conv_ch)
    );

    // Result and event registers, updated on every accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_seq   <= SEQ_A;
            res_ch    <= '0;
            res_last  <= 1'b0;
            seq_irq   <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_seq  <= conv_seq;
                res_ch   <= conv_ch;
                res_last <= pass_end[conv_seq];
            end
            for (int s = 0; s < NSEQ; s++) begin
                seq_irq[s] <= done_hit[s] && (!seq_evmode[s] || pass_end[s]);
            end
        end
    end
endmodule

// File: rtl/convseq_chk.sv
// Module: convseq_chk
// Property checker for convseq_sched, attached with bind below.
// Assumes a synchronous active-low reset held for at least two cycles.
module convseq_chk #(
    parameter int CHW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           conv_req,
    input logic           conv_done,
    input logic           conv_seq,
    input logic [CHW-1:0] conv_ch,
    input logic           res_valid,
    input logic           res_seq,
    input logic [CHW-1:0] res_ch,
    input logic [1:0]     seq_irq,
    input logic           res_last,
    input logic [1:0]     seq_evmode,
    input logic [1:0]     seq_en,
    input logic [1:0]     lane_want,
    input logic           prio_a
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_done |=> conv_req && $stable(conv_ch) && $stable(conv_seq));

    assert_req_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && conv_done |=> !conv_req);

    assert_res_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(conv_req && conv_done) && res_ch == $past(conv_ch)
                      && res_seq == $past(conv_seq));

    assert_irq_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_irq != 2'b00 |-> res_valid && $onehot(seq_irq) && seq_irq[res_seq]);

    assert_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_req) && $past(lane_want == 2'b11) |-> conv_seq == !$past(prio_a));

    for (genvar s = 0; s < 2; s++) begin : g_seq
        assert_pass_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid && res_seq == s[0] && !res_last && $past(seq_evmode[s]) |-> !seq_irq[s]);

        assert_each_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid && res_seq == s[0] && !$past(seq_evmode[s]) |-> seq_irq[s]);

        assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_want[s]) |-> $past(seq_en[s]));
    end
endmodule

bind convseq_sched convseq_chk #(.CHW(CHW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_req   (conv_req),
    .conv_done  (conv_done),
    .conv_seq   (conv_seq),
    .conv_ch    (conv_ch),
    .res_valid  (res_valid),
    .res_seq    (res_seq),
    .res_ch     (res_ch),
    .seq_irq    (seq_irq),
    .res_last   (res_last),
    .seq_evmode (seq_evmode),
    .seq_en     (seq_en),
    .lane_want  (lane_want),
    .prio_a     (prio_a)
);

// File: tb/convseq_sched_bench.sv
`timescale 1ns/1ps
module convseq_sched_bench;
    localparam int NCH   = 12;
    localparam int NTRIG = 6;
    localparam int CHW   = 4;
    localparam int LAT   = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] seq_en, seq_trigpol, seq_sync_bypass, seq_swstart;
    logic [1:0] seq_burst, seq_step, seq_evmode;
    logic prio_a;
    logic [2*NCH-1:0] seq_chmask;
    logic [2*NTRIG-1:0] seq_trigmask;
    logic [NTRIG-1:0] hw_trig;
    logic conv_req, conv_seq, conv_done;
    logic [CHW-1:0] conv_ch, res_ch;
    logic res_valid, res_seq, res_last;
    logic [1:0] seq_irq;

    convseq_sched #(.NCH(NCH), .NTRIG(NTRIG)) u_convseq_sched (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .prio_a(prio_a),
        .seq_chmask(seq_chmask), .seq_trigmask(seq_trigmask),
        .seq_trigpol(seq_trigpol), .seq_sync_bypass(seq_sync_bypass),
        .seq_swstart(seq_swstart), .seq_burst(seq_burst), .seq_step(seq_step),
        .seq_evmode(seq_evmode), .hw_trig(hw_trig), .conv_req(conv_req),
        .conv_seq(conv_seq), .conv_ch(conv_ch), .conv_done(conv_done),
        .res_valid(res_valid), .res_seq(res_seq), .res_ch(res_ch),
        .res_last(res_last), .seq_irq(seq_irq)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic           seq;
        logic [CHW-1:0] ch;
        logic           last;
        logic           irq;
    } exp_t;

    exp_t  q[$];
    exp_t  mon_e;
    int    n_run = 0;
    int    n_fail = 0;
    int    lat_cnt = 0;
    bit    ended = 1'b0;
    string cur_req = "R12";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_tb();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Converter model: answers each request after LAT sampled cycles.
    initial begin
        conv_done = 1'b0;
        forever begin
            @(negedge clk);
            if (conv_done) begin
                conv_done = 1'b0;
                lat_cnt   = 0;
            end else if (conv_req) begin
                lat_cnt++;
                if (lat_cnt >= LAT) conv_done = 1'b1;
            end
        end
    end

    // Monitor: pops the scoreboard on every result (R10, R7).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && res_valid === 1'b1) begin
            if (q.size() == 0) begin
                check(1'b0, cur_req, "unexpected result channel", int'(res_ch), -1);
            end else begin
                mon_e = q.pop_front();
                check(res_seq == mon_e.seq, cur_req, "R10 result sequence", int'(res_seq), int'(mon_e.seq));
                check(res_ch == mon_e.ch, cur_req, "R1 result channel", int'(res_ch), int'(mon_e.ch));
                check(res_last == mon_e.last, cur_req, "R10 end of pass", int'(res_last), int'(mon_e.last));
                check(seq_irq == (mon_e.irq ? (2'b01 << mon_e.seq) : 2'b00), cur_req,
                      "R7 event bits", int'(seq_irq), mon_e.irq ? (1 << mon_e.seq) : 0);
            end
        end else if (rst_n === 1'b1 && seq_irq !== 2'b00) begin
            check(1'b0, cur_req, "R7 event without result", int'(seq_irq), 0);
        end
    end

    task automatic push(input int s, input int ch, input bit last, input bit irq);
        exp_t e;
        e.seq = s[0]; e.ch = CHW'(ch); e.last = last; e.irq = irq;
        q.push_back(e);
    endtask

    task automatic kick(input int s);
        @(negedge clk); seq_swstart[s] = 1'b1;
        @(negedge clk); seq_swstart[s] = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(q.size() == 0, cur_req, "results still missing", q.size(), 0);
        repeat (16) @(negedge clk);
        check(conv_req == 1'b0, cur_req, "request idle after drain", int'(conv_req), 0);
    endtask

    task automatic no_req(input int cycles, input string req);
        int seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (conv_req) seen++;
        end
        check(seen == 0, req, "request cycles while none expected", seen, 0);
    endtask

    task automatic wait_req();
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!conv_req && t < 100);
    endtask

    task automatic latency(input int exp, input string req);
        int c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!conv_req && c < 20);
        check(c == exp, req, "trigger to request edges", c, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        finish_tb();
    end

    initial begin
        rst_n = 1'b0; seq_en = 2'b11; prio_a = 1'b0;
        seq_chmask = '0; seq_trigmask = '0; seq_trigpol = 2'b11;
        seq_sync_bypass = 2'b11; seq_swstart = 2'b00; seq_burst = 2'b00;
        seq_step = 2'b00; seq_evmode = 2'b00; hw_trig = '0;
        repeat (4) @(negedge clk);
        // R12: reset state
        check(conv_req == 0 && res_valid == 0 && seq_irq == 0, "R12", "outputs in reset",
              int'({conv_req, res_valid, seq_irq}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(conv_req == 0 && res_valid == 0, "R12", "outputs after reset",
              int'({conv_req, res_valid}), 0);

        // R1 R7 R10: A, ascending order, event per conversion
        cur_req = "R1 R7 R10";
        seq_chmask[NCH-1:0] = 12'hC49;
        push(0, 0, 0, 1); push(0, 3, 0, 1); push(0, 6, 0, 1);
        push(0, 10, 0, 1); push(0, 11, 1, 1);
        kick(0); drain();

        // R7: B, event only at end of pass
        cur_req = "R7";
        seq_evmode[1] = 1'b1;
        seq_chmask[2*NCH-1:NCH] = 12'h212;
        push(1, 1, 0, 0); push(1, 4, 0, 0); push(1, 9, 1, 1);
        kick(1); drain();
        seq_evmode[1] = 1'b0;

        // R2: disabled sequences ignore software and hardware launches
        cur_req = "R2";
        seq_en = 2'b00;
        seq_trigmask[NTRIG-1:0] = 6'b001000;
        kick(0); kick(1);
        @(negedge clk); hw_trig[3] = 1'b1;
        no_req(12, "R2");
        hw_trig[3] = 1'b0;
        no_req(12, "R2");
        seq_trigmask = '0;
        seq_en = 2'b11;
        no_req(4, "R2");

        // R3 R4: A rising edge on line 2, synchronizer bypassed
        cur_req = "R3 R4";
        seq_chmask[NCH-1:0] = 12'h080;
        seq_trigmask[NTRIG-1:0] = 6'b000100;
        @(negedge clk); hw_trig[1] = 1'b1;
        no_req(10, "R3");
        hw_trig[1] = 1'b0;
        push(0, 7, 1, 1);
        @(negedge clk); hw_trig[2] = 1'b1;
        latency(2, "R4");
        drain();
        hw_trig[2] = 1'b0;
        no_req(10, "R3");

        // R3 R4: B falling edge on line 0 through the synchronizer
        seq_trigmask = '0;
        seq_trigmask[2*NTRIG-1:NTRIG] = 6'b000001;
        seq_trigpol[1] = 1'b0;
        seq_sync_bypass[1] = 1'b0;
        seq_chmask[2*NCH-1:NCH] = 12'h200;
        @(negedge clk); hw_trig[0] = 1'b1;
        no_req(10, "R3");
        push(1, 9, 1, 1);
        hw_trig[0] = 1'b0;
        latency(4, "R4");
        drain();
        seq_trigmask = '0;

        // R5: single-step walks one channel per launch
        cur_req = "R5";
        seq_step[0] = 1'b1;
        seq_chmask[NCH-1:0] = 12'h006;
        push(0, 1, 0, 1); kick(0); drain();
        push(0, 2, 1, 1); kick(0); drain();
        push(0, 1, 0, 1); kick(0); drain();
        push(0, 2, 1, 1); kick(0); drain();
        seq_step[0] = 1'b0;

        // R9: second launch while running adds nothing
        cur_req = "R9";
        seq_chmask[NCH-1:0] = 12'h070;
        push(0, 4, 0, 1); push(0, 5, 0, 1); push(0, 6, 1, 1);
        kick(0); wait_req(); kick(0);
        drain();

        // R6: burst repeats, ignores starts, finishes pass after clearing
        cur_req = "R6";
        seq_evmode[1] = 1'b1;
        seq_chmask[2*NCH-1:NCH] = 12'h030;
        for (int p = 0; p < 3; p++) begin
            push(1, 4, 0, 0); push(1, 5, 1, 1);
        end
        @(negedge clk); seq_burst[1] = 1'b1;
        wait (q.size() <= 5);
        kick(1);
        wait (q.size() <= 1);
        @(negedge clk); seq_burst[1] = 1'b0;
        drain();
        seq_evmode[1] = 1'b0;

        // R8: B has priority and cuts into A's pass; A resumes
        cur_req = "R8";
        prio_a = 1'b0;
        seq_chmask[NCH-1:0] = 12'h00F;
        seq_chmask[2*NCH-1:NCH] = 12'h060;
        push(0, 0, 0, 1); push(1, 5, 0, 1); push(1, 6, 1, 1);
        push(0, 1, 0, 1); push(0, 2, 0, 1); push(0, 3, 1, 1);
        kick(0); wait_req(); kick(1);
        drain();

        // R8: A has priority and cuts into B's pass
        prio_a = 1'b1;
        seq_chmask[NCH-1:0] = 12'h100;
        seq_chmask[2*NCH-1:NCH] = 12'h00E;
        push(1, 1, 0, 1); push(0, 8, 1, 1); push(1, 2, 0, 1); push(1, 3, 1, 1);
        kick(1); wait_req(); kick(0);
        drain();

        // R3 R9: hardware edge and software start in one cycle give one pass
        cur_req = "R3 R9";
        seq_trigmask[NTRIG-1:0] = 6'b000100;
        seq_chmask[NCH-1:0] = 12'h800;
        push(0, 11, 1, 1);
        @(negedge clk); hw_trig[2] = 1'b1; seq_swstart[0] = 1'b1;
        @(negedge clk); seq_swstart[0] = 1'b0;
        drain();
        hw_trig[2] = 1'b0;
        no_req(8, "R3");

        finish_tb();
    end
endmodule